// File: doc/BRIEF.md
# Decoded Instruction Cache Tag Check

This block holds the tag side of a direct-mapped cache of already-decoded instructions. Each slot holds the physical fetch address it was filled for, a 32-bit stamp word and an opaque payload produced by an external decoder. A table with one stamp per 4 KB physical page holds the current stamp for every page. The low 29 bits of a stamp are a modification counter. The top 3 bits record the fetch mode that was active when the page was last filled from.

A slot is reused only while its address, its stamp and the mode bits all still agree with the current state. A lookup reports hit or miss one cycle after it is issued. After a miss, the fetch unit issues a fill. The fill re-stamps the page with the current mode and writes the slot. If decoding later fails, an invalidate command makes the slot unusable. A page-write command, issued when code on a page is stored to, advances that page's counter. This retires every slot filled from that page at once. One command is accepted per cycle.

Top module: `icache_tag_top`

## Requirements
- R1: The command code on `op_i` is 0 idle, 1 lookup, 2 fill, 3 invalidate and 4 page-write. The codes 5 to 7 change no state and raise no response. `rsp_valid_o` is high in exactly the cycle after a lookup is presented, and `rsp_hit_o` is never high without it.
- R2: The slot index is the low IDX_W address bits XOR address bits 12 and up, truncated to IDX_W bits, with zeros where the address has no such bit. `rsp_idx_o` returns the index of the lookup. A fill to a different address with the same index displaces the earlier slot.
- R3: A hit requires that the slot's stored address equals the lookup address and that the slot's stamp equals the current stamp of the page (address bits 12 and up).
- R4: A hit also requires that the page stamp's top 3 bits cover every bit set in `mode_i`, that is `(page_mode & mode_i) == mode_i`.
- R5: A fill forms the stamp {mode_i, low 29 bits of the current page stamp}. It writes that stamp to the page table, and it writes that stamp, the address and `fill_data_i` to the indexed slot. A following lookup with the same mode hits and returns the payload.
- R6: A fill under a different mode changes the page's mode bits. Slots filled earlier from that page then miss.
- R7: An invalidate sets the indexed slot's stamp to all ones. That slot never hits until it is filled again.
- R8: A page-write adds one to the low 29 bits of that page's stamp and keeps the mode bits. All slots filled from that page then miss. Slots from other pages are unaffected.
- R9: After reset every slot stamp is all ones, every page stamp is zero and `rsp_valid_o` is low, so every lookup misses.
- R10: `rsp_data_o` returns the slot payload on a hit and zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Command code |
| addr_i | input | PA_W | Physical fetch address for the command |
| mode_i | input | 3 | Current fetch-mode bits |
| fill_data_i | input | DATA_W | Decoded payload written by a fill |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_idx_o | output | IDX_W | Slot index of the lookup |
| rsp_data_o | output | DATA_W | Payload on hit, zero on miss |

## Verification
The bench targets two kinds of stale slot. In the first, two addresses share an index; a design that compared only the index would return the wrong payload. In the second, the page's stamp has moved on, through a counter bump or a fill under another mode; a design that ignored the stamp would hit on code that has been rewritten or decoded under another mode. Mode-superset lookups check that a subset mode still hits, while a disjoint mode must miss. Invalidated slots, reset state and undefined command codes are probed through later lookups. A long pseudo-random command sweep over four pages is compared against an arithmetic model of the stamp rules.

// File: rtl/icache_tag_pkg.sv
// Shared stamp layout, command codes and stamp update functions.
package icache_tag_pkg;
    localparam int CNT_W   = 29;
    localparam int MODE_W  = 3;
    localparam int STAMP_W = CNT_W + MODE_W;

    typedef logic [STAMP_W-1:0] stamp_t;

    localparam stamp_t STAMP_INVALID = '1;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_LOOKUP  = 3'd1,
        OP_FILL    = 3'd2,
        OP_INVAL   = 3'd3,
        OP_PGWRITE = 3'd4
    } op_e;

    // Keep the page counter, replace the mode bits with the current mode.
    function automatic stamp_t restamp(stamp_t old, logic [MODE_W-1:0] mode);
        return {mode, old[CNT_W-1:0]};
    endfunction

    // Advance the page counter, keep the mode bits.
    function automatic stamp_t bump(stamp_t old);
        return {old[STAMP_W-1 -: MODE_W], old[CNT_W-1:0] + CNT_W'(1)};
    endfunction
endpackage

// File: rtl/icache_page_stamps.sv
// Page stamp table: one stamp per 4 KB physical page.
// Assumes one write per cycle; the read is combinational from registers.
module icache_page_stamps
    import icache_tag_pkg::*;
#(
    parameter int PN_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PN_W-1:0] pn_i,
    input  logic            wr_en_i,
    input  stamp_t          wr_stamp_i,
    output stamp_t          rd_stamp_o
);
    localparam int DEPTH = 1 << PN_W;

    stamp_t pg_q [DEPTH];

    // Clear every page stamp on reset, otherwise write the selected page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < DEPTH; p++) begin
                pg_q[p] <= '0;
            end
        end else if (wr_en_i) begin
            pg_q[pn_i] <= wr_stamp_i;
        end
    end

    // Current stamp of the addressed page.
    assign rd_stamp_o = pg_q[pn_i];
endmodule

// File: rtl/icache_tag_store.sv
// Slot array: stored address, stamp and opaque payload per slot.
// Assumes write and invalidate never occur in the same cycle.
module icache_tag_store
    import icache_tag_pkg::*;
#(
    parameter int PA_W   = 22,
    parameter int IDX_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              wr_en_i,
    input  logic              inv_en_i,
    input  logic [PA_W-1:0]   wr_pa_i,
    input  stamp_t            wr_stamp_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [PA_W-1:0]   rd_pa_o,
    output stamp_t            rd_stamp_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [PA_W-1:0]   pa_arr  [DEPTH];
    stamp_t            st_arr  [DEPTH];
    logic [DATA_W-1:0] dat_arr [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic [PA_W-1:0]   pa_r;
        stamp_t            st_r;
        logic [DATA_W-1:0] dat_r;
        logic              sel;

        assign sel = (idx_i == IDX_W'(e));

        // Reset to invalid; fill writes the whole slot, invalidate the stamp only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pa_r  <= '0;
                st_r  <= STAMP_INVALID;
                dat_r <= '0;
            end else if (sel && wr_en_i) begin
                pa_r  <= wr_pa_i;
                st_r  <= wr_stamp_i;
                dat_r <= wr_data_i;
            end else if (sel && inv_en_i) begin
                st_r  <= STAMP_INVALID;
            end
        end

        assign pa_arr[e]  = pa_r;
        assign st_arr[e]  = st_r;
        assign dat_arr[e] = dat_r;
    end

    // Read the indexed slot.
    assign rd_pa_o    = pa_arr[idx_i];
    assign rd_stamp_o = st_arr[idx_i];
    assign rd_data_o  = dat_arr[idx_i];
endmodule

// File: rtl/icache_hit_compare.sv
// Three-way tag match: address, page stamp and mode coverage.
// Purely combinational; an all-ones slot stamp never matches.
module icache_hit_compare
    import icache_tag_pkg::*;
#(
    parameter int PA_W = 22
) (
    input  logic [PA_W-1:0]   lk_pa_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [PA_W-1:0]   slot_pa_i,
    input  stamp_t            slot_stamp_i,
    input  stamp_t            page_stamp_i,
    output logic              hit_o
);
    logic pa_eq, stamp_eq, mode_ok, slot_live;
    logic [MODE_W-1:0] page_mode;

    // Evaluate each match condition separately, then combine.
    always_comb begin
        page_mode = page_stamp_i[STAMP_W-1 -: MODE_W];
        pa_eq     = (slot_pa_i == lk_pa_i);
        stamp_eq  = (slot_stamp_i == page_stamp_i);
        mode_ok   = ((page_mode & mode_i) == mode_i);
        slot_live = (slot_stamp_i != STAMP_INVALID);
        hit_o     = pa_eq && stamp_eq && mode_ok && slot_live;
    end
endmodule

// File: rtl/icache_tag_top.sv
// Decoded instruction cache tag check, top level.
// Decodes the command, hashes the address to a slot, drives the page table
// and slot array updates, and registers the lookup response (1-cycle latency).
// Assumes PA_W > 12 and IDX_W <= PA_W.
module icache_tag_top
    import icache_tag_pkg::*;
#(
    parameter int PA_W   = 22,
    parameter int IDX_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [PA_W-1:0]   addr_i,
    input  logic [2:0]        mode_i,
    input  logic [DATA_W-1:0] fill_data_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [IDX_W-1:0]  rsp_idx_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    localparam int PAGE_SH = 12;
    localparam int PN_W    = PA_W - PAGE_SH;

    logic [IDX_W-1:0]  hi_fold, idx;
    logic [PN_W-1:0]   pn;
    logic              is_look, is_fill, is_inv, is_pgw;
    stamp_t            pg_stamp, pg_wr_stamp, fill_stamp;
    logic [PA_W-1:0]   slot_pa;
    stamp_t            slot_stamp;
    logic [DATA_W-1:0] slot_data;
    logic              hit;

    logic              rsp_valid_q, rsp_hit_q;
    logic [IDX_W-1:0]  rsp_idx_q;
    logic [DATA_W-1:0] rsp_data_q;

    // Page-number bits folded into the index, zero where the address ends.
    for (genvar b = 0; b < IDX_W; b++) begin : g_fold
        if (PAGE_SH + b < PA_W) begin : g_bit
            assign hi_fold[b] = addr_i[PAGE_SH + b];
        end else begin : g_zero
            assign hi_fold[b] = 1'b0;
        end
    end

    assign idx = addr_i[IDX_W-1:0] ^ hi_fold;
    assign pn  = addr_i[PA_W-1:PAGE_SH];

    // Command decode; undefined codes select nothing.
    always_comb begin
        is_look = (op_i == OP_LOOKUP);
        is_fill = (op_i == OP_FILL);
        is_inv  = (op_i == OP_INVAL);
        is_pgw  = (op_i == OP_PGWRITE);
    end

    // New page stamp for a fill or a page-write.
    always_comb begin
        fill_stamp  = restamp(pg_stamp, mode_i);
        pg_wr_stamp = is_fill ? fill_stamp : bump(pg_stamp);
    end

    icache_page_stamps #(.PN_W(PN_W)) pages_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pn_i       (pn),
        .wr_en_i    (is_fill || is_pgw),
        .wr_stamp_i (pg_wr_stamp),
        .rd_stamp_o (pg_stamp)
    );

    icache_tag_store #(.PA_W(PA_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) slots_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_i      (idx),
        .wr_en_i    (is_fill),
        .inv_en_i   (is_inv),
        .wr_pa_i    (addr_i),
        .wr_stamp_i (fill_stamp),
        .wr_data_i  (fill_data_i),
        .rd_pa_o    (slot_pa),
        .rd_stamp_o (slot_stamp),
        .rd_data_o  (slot_data)
    );

    icache_hit_compare #(.PA_W(PA_W)) cmp_i (
        .lk_pa_i      (addr_i),
        .mode_i       (mode_i),
        .slot_pa_i    (slot_pa),
        .slot_stamp_i (slot_stamp),
        .page_stamp_i (pg_stamp),
        .hit_o        (hit)
    );

    // Register the lookup response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_idx_q   <= '0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= is_look;
            rsp_hit_q   <= is_look && hit;
            if (is_look) begin
                rsp_idx_q  <= idx;
                rsp_data_q <= hit ? slot_data : '0;
            end
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_hit_o   = rsp_hit_q;
    assign rsp_idx_o   = rsp_idx_q;
    assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/icache_tag_check.sv
// Protocol checker for icache_tag_top, attached by bind.
module icache_tag_check
    import icache_tag_pkg::*;
#(
    parameter int PA_W = 22
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      op_i,
    input logic [PA_W-1:0] addr_i,
    input logic [2:0]      mode_i,
    input logic            rsp_valid_o,
    input logic            rsp_hit_o
);
    AST_RSP_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOOKUP) |=> rsp_valid_o);   // R1
    AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_LOOKUP) |=> !rsp_valid_o);  // R1
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> rsp_valid_o);             // R1
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOOKUP && $past(op_i) == OP_FILL && $past(rst_n)
         && addr_i == $past(addr_i) && mode_i == $past(mode_i)) |=> rsp_hit_o); // R5
    AST_INVAL_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOOKUP && $past(op_i) == OP_INVAL && $past(rst_n)
         && addr_i == $past(addr_i)) |=> !rsp_hit_o);  // R7
    AST_PGWRITE_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOOKUP && $past(op_i) == OP_PGWRITE && $past(rst_n)
         && addr_i[PA_W-1:12] == $past(addr_i[PA_W-1:12])) |=> !rsp_hit_o); // R8
endmodule

bind icache_tag_top icache_tag_check #(.PA_W(PA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .addr_i      (addr_i),
    .mode_i      (mode_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o)
);

// File: tb/icache_tag_top_tb_top.sv
module icache_tag_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PA_W   = 16;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 8;
    localparam int NSLOT  = 1 << IDX_W;
    localparam int NPAGE  = 1 << (PA_W - 12);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        op = 3'd0;
    logic [PA_W-1:0]   addr = '0;
    logic [2:0]        mode = 3'd0;
    logic [DATA_W-1:0] fdata = '0;
    logic              rsp_valid, rsp_hit;
    logic [IDX_W-1:0]  rsp_idx;
    logic [DATA_W-1:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    logic [PA_W-1:0]   m_pa  [NSLOT];
    logic [31:0]       m_st  [NSLOT];
    logic [DATA_W-1:0] m_dat [NSLOT];
    logic [31:0]       m_pg  [NPAGE];

    icache_tag_top #(.PA_W(PA_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .addr_i(addr), .mode_i(mode),
        .fill_data_i(fdata), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
        .rsp_idx_o(rsp_idx), .rsp_data_o(rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [IDX_W-1:0] hidx(input logic [PA_W-1:0] a);
        logic [PA_W-1:0] s = a >> 12;
        return a[IDX_W-1:0] ^ s[IDX_W-1:0];
    endfunction

    function automatic bit model_hit(input logic [PA_W-1:0] a, input logic [2:0] m);
        logic [IDX_W-1:0] i = hidx(a);
        logic [31:0] ps = m_pg[a >> 12];
        return (m_pa[i] == a) && (m_st[i] == ps) && (m_st[i] != 32'hFFFF_FFFF)
               && ((ps[31:29] & m) == m);
    endfunction

    // Apply one command and check the response against the model.
    task automatic do_op(input logic [2:0] o, input logic [PA_W-1:0] a,
                         input logic [2:0] m, input logic [DATA_W-1:0] d, input string req);
        logic [IDX_W-1:0] i;
        logic [31:0] ps;
        bit eh;
        @(negedge clk);
        op = o; addr = a; mode = m; fdata = d;
        i = hidx(a);
        ps = m_pg[a >> 12];
        eh = model_hit(a, m);
        @(posedge clk);
        #2;
        if (o == 3'd1) begin
            check(rsp_valid == 1'b1, {req, " R1 valid"}, 32'(rsp_valid), 32'd1);
            check(rsp_hit == eh, {req, " hit"}, 32'(rsp_hit), 32'(eh));
            check(rsp_idx == i, {req, " R2 idx"}, 32'(rsp_idx), 32'(i));
            check(rsp_data == (eh ? m_dat[i] : '0), {req, " R10 data"}, 32'(rsp_data),
                  32'(eh ? m_dat[i] : '0));
        end else begin
            check(rsp_valid == 1'b0, {req, " R1 no response"}, 32'(rsp_valid), 32'd0);
        end
        case (o)
            3'd2: begin
                m_pg[a >> 12] = {m, ps[28:0]};
                m_pa[i] = a; m_st[i] = {m, ps[28:0]}; m_dat[i] = d;
            end
            3'd3: m_st[i] = 32'hFFFF_FFFF;
            3'd4: m_pg[a >> 12] = {ps[31:29], ps[28:0] + 29'd1};
            default: ;
        endcase
    endtask

    task automatic look_expect(input logic [PA_W-1:0] a, input logic [2:0] m,
                               input bit exp_hit, input string req);
        do_op(3'd1, a, m, '0, req);
        check(rsp_hit == exp_hit, {req, " directed"}, 32'(rsp_hit), 32'(exp_hit));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired before completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int s = 0; s < NSLOT; s++) begin
            m_pa[s] = '0; m_st[s] = 32'hFFFF_FFFF; m_dat[s] = '0;
        end
        for (int p = 0; p < NPAGE; p++) m_pg[p] = '0;
        repeat (3) @(posedge clk);
        #2;
        check(rsp_valid == 1'b0, "R9 reset valid", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: every slot misses after reset, including address zero
        for (int s = 0; s < NSLOT; s++) look_expect(PA_W'(s), 3'd0, 1'b0, "R9 reset miss");

        // R5: fill then hit with payload
        do_op(3'd2, 16'h1234, 3'd5, 8'hA5, "R5 fill");
        look_expect(16'h1234, 3'd5, 1'b1, "R5 hit");
        // R4: mode coverage
        look_expect(16'h1234, 3'd1, 1'b1, "R4 subset mode");
        look_expect(16'h1234, 3'd0, 1'b1, "R4 empty mode");
        look_expect(16'h1234, 3'd2, 1'b0, "R4 uncovered mode");
        // R3: same index, other address
        look_expect(16'h0005, 3'd5, 1'b0, "R3 address mismatch");
        // R2: alias displaces earlier slot (both index 5)
        do_op(3'd2, 16'h0005, 3'd1, 8'h3C, "R2 alias fill");
        look_expect(16'h0005, 3'd1, 1'b1, "R2 alias hit");
        look_expect(16'h1234, 3'd5, 1'b0, "R2 displaced");
        // R1: undefined codes do nothing
        do_op(3'd5, 16'h0005, 3'd0, 8'h00, "R1 code5");
        do_op(3'd7, 16'h0005, 3'd0, 8'h00, "R1 code7");
        look_expect(16'h0005, 3'd1, 1'b1, "R1 still hit");
        // R8: page write on page 0 only
        do_op(3'd2, 16'h2010, 3'd1, 8'h77, "R8 fill other page");
        do_op(3'd4, 16'h0FFF, 3'd0, 8'h00, "R8 page write");
        look_expect(16'h0005, 3'd1, 1'b0, "R8 page retired");
        look_expect(16'h2010, 3'd1, 1'b1, "R8 other page kept");
        do_op(3'd2, 16'h0005, 3'd1, 8'h99, "R8 refill");
        look_expect(16'h0005, 3'd1, 1'b1, "R8 refill hit");
        // R6: fill under a new mode retires older slots of that page
        do_op(3'd2, 16'h2013, 3'd2, 8'h44, "R6 fill new mode");
        look_expect(16'h2010, 3'd1, 1'b0, "R6 old mode slot");
        look_expect(16'h2013, 3'd2, 1'b1, "R6 new slot");
        // R7: invalidate
        do_op(3'd3, 16'h2013, 3'd0, 8'h00, "R7 invalidate");
        look_expect(16'h2013, 3'd2, 1'b0, "R7 miss");
        look_expect(16'h2013, 3'd0, 1'b0, "R7 miss any mode");

        // Sweep: pseudo-random commands over four pages against the model (R3 R4 R5 R6 R7 R8)
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] o;
            logic [PA_W-1:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[3:0])
                4'd0, 4'd1, 4'd2, 4'd3: o = 3'd2;
                4'd4: o = 3'd3;
                4'd5: o = 3'd4;
                4'd6: o = 3'd6;
                default: o = 3'd1;
            endcase
            a = PA_W'({lfsr[5:4], 12'h000}) | PA_W'(lfsr[11:6]);
            do_op(o, a, lfsr[14:12], lfsr[15:8], "R3 sweep");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule